// File: doc/BRIEF.md
# Clock-Ratio Detect and Startup Sequencer

This block sits in the master-clock domain of an audio converter's digital front end. It watches the incoming frame clock and bit clock and measures how many master-clock cycles fit in one frame. It accepts only a small set of allowed ratios, and from the accepted ratio it infers the sample-rate class (speed mode) that the interpolation path needs. Until a ratio has been confirmed and a settling interval has elapsed, the block holds the data path at zero.

The settling interval is counted in frames and doubles with each faster speed class. If the frame or bit clock falls silent, or an unexpected period shows up, the block drops back to its held state. If the master clock itself stops, the block also drops back; a slow free-running watchdog clock sees that the master domain no longer answers. Every recovery repeats the full detection and settling sequence.

The block drives three outputs. The first is the speed code, which the downstream filters use. The second is a data-path enable. The third is a force-zero flag, the exact complement of the enable, which the output stage uses to clamp the samples.

Top module: `clk_ratio_seq`

## Requirements
- R1: While reset is asserted and immediately after it, `dp_enable` is 0, `force_zero` is 1 and `speed_mode` is 2'b00.
- R2: An accepted period of 512, 768 or 1152 master clocks per frame sets `speed_mode` to 2'b00 (normal rate).
- R3: An accepted period of 256 or 384 sets `speed_mode` to 2'b01 (double rate). An accepted period of 128 or 192 sets it to 2'b10 (quad rate). The code 2'b11 never appears.
- R4: A period is measured between consecutive rising edges of the synchronised frame clock. A ratio is accepted only when two back-to-back periods equal the same allowed value, so lock comes on the third rising frame edge after clocks appear.
- R5: After lock, `dp_enable` rises once SETTLE_BASE further rising frame edges have been seen at normal rate. The count is 2×SETTLE_BASE at double rate and 4×SETTLE_BASE at quad rate (default SETTLE_BASE = 176). While the master clock runs, `force_zero` is the complement of `dp_enable`.
- R6: A period that matches no allowed ratio removes lock and clears `dp_enable`. The block stays muted until two matching periods are seen again.
- R7: When the frame clock or the bit clock shows no edge for STOP_LIMIT master cycles (default 4096), lock is lost and the output is muted. After a frame-clock stop, the first returning frame edge only clears the stop condition.
- R8: When the master clock stops, `dp_enable` falls to 0 and `force_zero` rises to 1 within WD_LIMIT plus a few cycles of the free-running watchdog clock, with no master-clock edge needed.
- R9: After any loss (bad period, stopped clock, stopped master clock), the enable returns only after the complete detection and settling sequence.
- R10: `speed_mode` keeps the most recently accepted mode while lock is lost. It changes only when a new lock is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; all sequencing runs on it |
| wd_clk | input | 1 | Free-running slow clock for the master-clock watchdog |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| frame_clk | input | 1 | Frame (left/right) clock, asynchronous to `mclk` |
| bit_clk | input | 1 | Serial bit clock, asynchronous to `mclk` |
| speed_mode | output | 2 | 00 normal, 01 double, 10 quad |
| dp_enable | output | 1 | High when the data path may pass samples |
| force_zero | output | 1 | High when the data path must output zero |

## Verification
Several properties are checked on every master-clock cycle:
- Lock only ever rises on the cycle after a frame edge.
- The enable never stands without lock in the cycle before.
- A bad period or a stopped-clock flag clears the enable within the next two cycles.
- The speed code never takes the illegal value and holds steady while the path is enabled.

Other behaviour is only visible across whole scenarios, and the bench covers it. This includes the exact frame count of the settling interval for each of the seven ratios, acceptance on the third edge, and recovery after a bit-clock or frame-clock pause. It also covers the watchdog response when the master clock itself is halted, which no assertion clocked by that clock can observe.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

   typedef enum logic [1:0] {
      SPD_NORMAL = 2'd0,
      SPD_DOUBLE = 2'd1,
      SPD_QUAD   = 2'd2
   } speed_e;

   typedef enum logic [1:0] {
      SQ_HOLD   = 2'd0,
      SQ_SETTLE = 2'd1,
      SQ_RUN    = 2'd2
   } seq_e;

   localparam int NUM_RATIOS = 7;
   localparam int MAX_RATIO  = 1152;

   typedef struct packed {
      logic       valid;
      logic [2:0] idx;
      speed_e     speed;
   } ratio_cls_t;

   // allowed master-clock-per-frame ratios, ascending
   function automatic int unsigned ratio_at(int i);
      case (i)
         0:       return 128;
         1:       return 192;
         2:       return 256;
         3:       return 384;
         4:       return 512;
         5:       return 768;
         default: return 1152;
      endcase
   endfunction

   function automatic speed_e speed_of(int i);
      if (i < 2)      return SPD_QUAD;
      else if (i < 4) return SPD_DOUBLE;
      else            return SPD_NORMAL;
   endfunction

   function automatic ratio_cls_t classify(int unsigned period);
      ratio_cls_t c;
      c.valid = 1'b0;
      c.idx   = 3'd0;
      c.speed = SPD_NORMAL;
      for (int i = 0; i < NUM_RATIOS; i++) begin
         if (period == ratio_at(i)) begin
            c.valid = 1'b1;
            c.idx   = 3'(i);
            c.speed = speed_of(i);
         end
      end
      return c;
   endfunction

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cs_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/cs_activity.sv
module cs_activity #(
   parameter int LIMIT = 4096,
   localparam int W    = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic dead
);
   logic         prev;
   logic [W-1:0] quiet;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= 1'b0;
         quiet <= '0;
      end else begin
         prev <= sig;
         if (sig != prev)
            quiet <= '0;
         else if (quiet != W'(LIMIT))
            quiet <= quiet + 1'b1;
      end
   end

   assign dead = (quiet == W'(LIMIT));
endmodule

// File: rtl/cs_mclk_wd.sv
module cs_mclk_wd #(
   parameter int WD_LIMIT    = 16,
   parameter int SYNC_STAGES = 2,
   localparam int W          = $clog2(WD_LIMIT + 1)
) (
   input  logic wd_clk,
   input  logic mclk,
   input  logic rst_n,
   output logic dead_w,
   output logic dead_m
);
   logic         req;
   logic         ack_m;
   logic         ack_w;
   logic [W-1:0] wait_cnt;

   // master side echoes the request toggle back
   cs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(mclk), .rst_n(rst_n), .d(req), .q(ack_m));

   cs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(wd_clk), .rst_n(rst_n), .d(ack_m), .q(ack_w));

   cs_sync #(.STAGES(SYNC_STAGES)) u_dead_sync (
      .clk(mclk), .rst_n(rst_n), .d(dead_w), .q(dead_m));

   always_ff @(posedge wd_clk or negedge rst_n) begin
      if (!rst_n) begin
         req      <= 1'b0;
         wait_cnt <= '0;
         dead_w   <= 1'b0;
      end else if (ack_w == req) begin
         req      <= ~req;
         wait_cnt <= '0;
         dead_w   <= 1'b0;
      end else if (wait_cnt == W'(WD_LIMIT)) begin
         dead_w <= 1'b1;
      end else begin
         wait_cnt <= wait_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/cs_ratio_det.sv
module cs_ratio_det
   import clkseq_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   frame_s,
   input  logic   flush,
   output logic   frame_rise,
   output logic   bad_period,
   output logic   locked,
   output speed_e speed
);
   logic             prev_f;
   logic [CNT_W-1:0] cnt;
   logic             have_edge;
   logic             prev_ok;
   logic [2:0]       prev_idx;
   ratio_cls_t       cls;

   assign frame_rise = frame_s & ~prev_f;
   assign cls        = classify(32'(cnt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_f     <= 1'b0;
         cnt        <= CNT_W'(1);
         have_edge  <= 1'b0;
         prev_ok    <= 1'b0;
         prev_idx   <= '0;
         locked     <= 1'b0;
         speed      <= SPD_NORMAL;
         bad_period <= 1'b0;
      end else begin
         prev_f     <= frame_s;
         bad_period <= 1'b0;
         if (flush) begin
            cnt       <= CNT_W'(1);
            have_edge <= 1'b0;
            prev_ok   <= 1'b0;
            locked    <= 1'b0;
         end else if (frame_rise) begin
            cnt       <= CNT_W'(1);
            have_edge <= 1'b1;
            if (have_edge) begin
               if (!cls.valid) begin
                  bad_period <= 1'b1;
                  locked     <= 1'b0;
                  prev_ok    <= 1'b0;
               end else begin
                  prev_ok  <= 1'b1;
                  prev_idx <= cls.idx;
                  if (prev_ok && (prev_idx == cls.idx)) begin
                     if (!locked) speed <= cls.speed;
                     locked <= 1'b1;
                  end else begin
                     locked <= 1'b0;
                  end
               end
            end
         end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cs_start_seq.sv
module cs_start_seq
   import clkseq_pkg::*;
#(
   parameter int SETTLE_BASE = 176,
   localparam int SET_W      = $clog2(SETTLE_BASE * 4 + 1)
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   locked,
   input  speed_e speed,
   input  logic   frame_rise,
   output logic   run
);
   seq_e             state;
   logic [SET_W-1:0] fcnt;
   logic [SET_W-1:0] target;

   assign target = SET_W'(SETTLE_BASE) << speed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_HOLD;
         fcnt  <= '0;
      end else if (!locked) begin
         state <= SQ_HOLD;
         fcnt  <= '0;
      end else begin
         case (state)
            SQ_HOLD: begin
               state <= SQ_SETTLE;
               fcnt  <= '0;
            end
            SQ_SETTLE: begin
               if (frame_rise) begin
                  if (fcnt + 1'b1 == target) state <= SQ_RUN;
                  else                       fcnt  <= fcnt + 1'b1;
               end
            end
            default: state <= SQ_RUN;
         endcase
      end
   end

   assign run = (state == SQ_RUN);
endmodule

// File: rtl/clk_ratio_seq.sv
module clk_ratio_seq
   import clkseq_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int SETTLE_BASE = 176,
   parameter int STOP_LIMIT  = 4096,
   parameter int WD_LIMIT    = 16,
   parameter int SYNC_STAGES = 2,
   localparam int NMON       = 2
) (
   input  logic       mclk,
   input  logic       wd_clk,
   input  logic       rst_n,
   input  logic       frame_clk,
   input  logic       bit_clk,
   output logic [1:0] speed_mode,
   output logic       dp_enable,
   output logic       force_zero
);
   generate
      if ((1 << CNT_W) <= MAX_RATIO) begin : g_bad_cnt
         $error("CNT_W too narrow for the largest ratio");
      end
      if (STOP_LIMIT <= MAX_RATIO) begin : g_bad_stop
         $error("STOP_LIMIT must exceed the longest frame");
      end
      if (SETTLE_BASE < 1 || WD_LIMIT < 4) begin : g_bad_time
         $error("SETTLE_BASE and WD_LIMIT out of range");
      end
   endgenerate

   logic [NMON-1:0] raw_clk;
   logic [NMON-1:0] sync_clk;
   logic [NMON-1:0] dead_v;
   logic            clk_stop;
   logic            mclk_dead_w;
   logic            mclk_dead_m;
   logic            frame_rise;
   logic            bad_period;
   logic            det_locked;
   speed_e          det_speed;
   logic            run;

   assign raw_clk = {bit_clk, frame_clk};

   // index 0 watches the frame clock, index 1 the bit clock
   for (genvar g = 0; g < NMON; g++) begin : g_mon
      cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(mclk), .rst_n(rst_n), .d(raw_clk[g]), .q(sync_clk[g]));
      cs_activity #(.LIMIT(STOP_LIMIT)) u_act (
         .clk(mclk), .rst_n(rst_n), .sig(sync_clk[g]), .dead(dead_v[g]));
   end

   assign clk_stop = |dead_v;

   cs_mclk_wd #(.WD_LIMIT(WD_LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_wd (
      .wd_clk(wd_clk), .mclk(mclk), .rst_n(rst_n),
      .dead_w(mclk_dead_w), .dead_m(mclk_dead_m));

   cs_ratio_det #(.CNT_W(CNT_W)) u_det (
      .clk(mclk), .rst_n(rst_n), .frame_s(sync_clk[0]),
      .flush(clk_stop | mclk_dead_m), .frame_rise(frame_rise),
      .bad_period(bad_period), .locked(det_locked), .speed(det_speed));

   cs_start_seq #(.SETTLE_BASE(SETTLE_BASE)) u_seq (
      .clk(mclk), .rst_n(rst_n), .locked(det_locked), .speed(det_speed),
      .frame_rise(frame_rise), .run(run));

   assign speed_mode = det_speed;
   assign dp_enable  = run & ~mclk_dead_w;
   assign force_zero = ~dp_enable;
endmodule

// File: rtl/clk_ratio_seq_chk.sv
module clk_ratio_seq_chk (
   input logic       mclk,
   input logic       rst_n,
   input logic       dp_enable,
   input logic [1:0] speed_mode,
   input logic       locked,
   input logic       frame_rise,
   input logic       bad_period,
   input logic       clk_stop
);
   // R3
   mode_legal_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      speed_mode != 2'b11);

   // R4
   lock_on_edge_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      $rose(locked) |-> $past(frame_rise));

   // R5
   en_needs_lock_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      dp_enable |-> $past(locked));

   // R6
   bad_drop_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      bad_period |=> !dp_enable);

   // R7
   stop_drop_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      clk_stop |=> ##1 !dp_enable);

   // R10
   mode_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      (dp_enable && $past(dp_enable)) |-> $stable(speed_mode));
endmodule

bind clk_ratio_seq clk_ratio_seq_chk u_chk (
   .mclk(mclk), .rst_n(rst_n), .dp_enable(dp_enable),
   .speed_mode(speed_mode), .locked(det_locked), .frame_rise(frame_rise),
   .bad_period(bad_period), .clk_stop(clk_stop));

// File: tb/tb_clk_ratio_seq.sv
`timescale 1ns/1ps
module tb_clk_ratio_seq;
   localparam int SB    = 6;
   localparam int STOPL = 1500;

   logic mclk = 0, wd_clk = 0, rst_n = 0;
   logic fclk = 0, bclk = 0;
   logic [1:0] speed_mode;
   logic dp_enable, force_zero;

   logic clk_run = 1, gen_on = 0, fclk_on = 1, bclk_on = 1;
   int   ratio_req = 256, cur_ratio = 256, ph = 0, gr;
   logic [1:0] bdiv = 0;
   int   checks = 0, errors = 0;

   clk_ratio_seq #(.SETTLE_BASE(SB), .STOP_LIMIT(STOPL)) dut (
      .mclk(mclk), .wd_clk(wd_clk), .rst_n(rst_n), .frame_clk(fclk),
      .bit_clk(bclk), .speed_mode(speed_mode), .dp_enable(dp_enable),
      .force_zero(force_zero));

   always begin #2.5; if (clk_run) mclk = ~mclk; end
   always #18.5 wd_clk = ~wd_clk;

   // stimulus generator, updates away from the active edge
   always @(negedge mclk) begin
      if (!gen_on) begin
         fclk <= 0; bclk <= 0; ph <= 0; bdiv <= 0;
      end else begin
         gr = (ph == 0) ? ratio_req : cur_ratio;
         if (ph == 0) cur_ratio <= ratio_req;
         fclk <= fclk_on ? (ph < gr / 2) : 1'b0;
         ph   <= (ph + 1 >= gr) ? 0 : ph + 1;
         if (bclk_on) begin
            bdiv <= bdiv + 1;
            if (bdiv[0]) bclk <= ~bclk;
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic rises_half(int n);
      repeat (n) @(posedge fclk);
      repeat (ratio_req / 2) @(posedge mclk);
      #1;
   endtask

   task automatic do_reset();
      gen_on = 0; fclk_on = 1; bclk_on = 1; clk_run = 1;
      rst_n = 0;
      repeat (4) @(posedge mclk);
      #1;
      rst_n = 1;
      repeat (2) @(posedge mclk);
      #1;
   endtask

   task automatic t_reset();
      gen_on = 0; rst_n = 0;
      repeat (3) @(posedge mclk);
      #1;
      chk("R1 enable in reset", dp_enable, 0);
      chk("R1 force_zero in reset", force_zero, 1);
      chk("R1 mode in reset", speed_mode, 0);
      rst_n = 1;
      repeat (3) @(posedge mclk);
      #1;
      chk("R1 enable after reset", dp_enable, 0);
   endtask

   task automatic run_ratio(int r, int m);
      string tag;
      int n;
      tag = (m == 0) ? "R2" : "R3";
      n = SB << m;
      do_reset();
      ratio_req = r; gen_on = 1;
      rises_half(2);
      chk("R4 not locked after two edges", speed_mode, 0);
      chk("R4 muted after two edges", dp_enable, 0);
      rises_half(1);
      chk({tag, " mode after lock"}, speed_mode, m);
      chk("R5 muted right after lock", force_zero, 1);
      rises_half(n - 1);
      chk("R5 still muted one frame early", dp_enable, 0);
      rises_half(1);
      chk("R5 enabled after settle", dp_enable, 1);
      chk("R5 force_zero cleared", force_zero, 0);
   endtask

   task automatic t_bad_ratio();
      int n;
      n = SB << 1;
      ratio_req = 300;
      rises_half(2);
      chk("R6 muted after bad period", dp_enable, 0);
      chk("R6 force_zero after bad period", force_zero, 1);
      chk("R10 mode held while unlocked", speed_mode, 1);
      rises_half(3);
      chk("R6 stays muted", dp_enable, 0);
      ratio_req = 256;
      rises_half(3 + n - 1);
      chk("R9 muted before full resettle", dp_enable, 0);
      rises_half(1);
      chk("R9 enabled after resettle", dp_enable, 1);
   endtask

   task automatic t_bit_stop();
      int n;
      n = SB << 1;
      bclk_on = 0;
      repeat (1000) @(posedge mclk);
      #1;
      chk("R7 bit clock gap below limit keeps enable", dp_enable, 1);
      repeat (STOPL - 1000 + 20) @(posedge mclk);
      #1;
      chk("R7 bit clock stop mutes", force_zero, 1);
      @(posedge fclk);
      repeat (20) @(posedge mclk);
      bclk_on = 1;
      rises_half(3);
      chk("R9 muted after bit clock returns", dp_enable, 0);
      rises_half(n - 1);
      chk("R9 muted one frame before resettle", dp_enable, 0);
      rises_half(1);
      chk("R9 enabled after bit clock recovery", dp_enable, 1);
   endtask

   task automatic t_frame_stop();
      int n;
      n = SB << 1;
      fclk_on = 0;
      repeat (STOPL + 20) @(posedge mclk);
      #1;
      chk("R7 frame clock stop mutes", dp_enable, 0);
      fclk_on = 1;
      rises_half(3 + n);
      chk("R7 first returning edge only clears stop", dp_enable, 0);
      rises_half(1);
      chk("R9 enabled after frame clock recovery", dp_enable, 1);
   endtask

   task automatic t_mclk_stop();
      int n;
      n = SB << 1;
      @(posedge mclk);
      #1;
      clk_run = 0;
      #1000;
      chk("R8 enable drops with master clock stopped", dp_enable, 0);
      chk("R8 force_zero with master clock stopped", force_zero, 1);
      clk_run = 1;
      rises_half(2);
      chk("R9 muted after master clock returns", dp_enable, 0);
      rises_half(2 + n);
      chk("R9 enabled after master clock recovery", dp_enable, 1);
   endtask

   initial begin
      #900000;
      errors++; checks++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      run_ratio(128, 2);
      run_ratio(192, 2);
      run_ratio(256, 1);
      run_ratio(384, 1);
      run_ratio(512, 0);
      run_ratio(768, 0);
      run_ratio(1152, 0);
      run_ratio(256, 1);
      t_bad_ratio();
      t_bit_stop();
      t_frame_stop();
      t_mclk_stop();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule